// File: doc/BRIEF.md
# Power Failure Status Capture Register

This block keeps three sticky fault flags that describe how the platform last lost power. It watches the main power-good line, the processor regulator power-good line and an active-low sleep control line, and it qualifies each observation with the current system power state. A flag that has been set stays set until its own clear rule removes it. Software reads all three flags as one 3-bit word and clears them through a single write strobe.

The regulator power-good line is looked at only on pulses of a slow sampling enable, so a short low glitch that falls between two samples goes unseen. Main power-good is synchronised and checked on every clock. The sleep-width flag comes from a timer. The timer is armed either by the sleep line asserting while the platform enters a deep sleep state, or by the resume-well reset releasing while the platform leaves the mechanical-off state. The flag is raised when the sleep line drops back before a programmable number of slow ticks has passed.

Top module: `pwr_fault_status`

## Requirements
- R1: After `rst_n` is released and before any fault stimulus, `rd_data` reads 3'b000. Bit 0 is the main power-good failure flag, bit 1 is the regulator power-good failure flag and bit 2 is the sleep-width violation flag.
- R2: `pwr_state` is encoded S0=0, S1=1, S3=3, S4=4, S5=5, G3=7. A falling edge of the synchronised `main_pg` sets bit 0 when `pwr_state` is S0 or S1. A falling edge in any other state leaves bit 0 unchanged.
- R3: Bit 0 is cleared by a write with `wr_data[0]`=1, is left unchanged by a write with `wr_data[0]`=0, and is cleared while `pwr_state` is G3.
- R4: Bit 1 is set when `vrm_pg` was high at one `tick` sample and low at the next, provided `pwr_state` is S0 or S1 at the second sample. A low pulse that starts and ends between two ticks, or a fall seen in S3, leaves bit 1 clear.
- R5: Bit 1 is cleared by a write with `wr_data[1]`=0 and left unchanged by a write with `wr_data[1]`=1.
- R6: A high-to-low transition of `sleep_n` while `pwr_state` is S4 or S5 starts the width timer. If `sleep_n` returns high after fewer ticks than the minimum width, bit 2 is set. If it returns high after at least that many ticks, bit 2 stays clear.
- R7: A low-to-high transition of `rsm_rst_n` while `pwr_state` is G3 also starts the width timer, and a short assertion that follows it sets bit 2.
- R8: The minimum width equals (`min_sel`+1) times `TICKS_PER_SEC` ticks.
- R9: Bit 2 is cleared by a write with `wr_data[2]`=1 and is held clear while `rsm_rst_n` is low.
- R10: When a hardware set and a software clear of the same bit fall in the same cycle, the bit ends up set.
- R11: A high-to-low transition of `sleep_n` in S3 does not start the timer, so a short assertion there leaves bit 2 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low block reset |
| tick | input | 1 | One-cycle slow sampling enable |
| rsm_rst_n | input | 1 | Active-low resume-well reset |
| sleep_n | input | 1 | Active-low sleep control line being timed |
| vrm_pg | input | 1 | Processor regulator power-good |
| main_pg | input | 1 | Main power-good |
| pwr_state | input | 3 | Current system power state (encoding in R2) |
| min_sel | input | 2 | Minimum sleep assertion width select |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 3 | Status write data |
| rd_data | output | 3 | Status flags |

## Verification
Power-good falls are applied in both qualifying and non-qualifying states. This separates state-gated capture from plain edge capture. Regulator glitches are placed both between slow ticks and across one, which shows that the line is sampled rather than watched on every clock. Sleep assertions are sized one tick short of and exactly at the minimum for several select values, and they are started by each of the two arming events and by a non-arming state. This pins down the width mapping and the start conditions. Writes of both polarities to each bit, plus a clear timed to coincide with a detected fall, tell the three clear rules and the set priority apart.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
   typedef enum logic [2:0] {
      PS_S0 = 3'd0,
      PS_S1 = 3'd1,
      PS_S3 = 3'd3,
      PS_S4 = 3'd4,
      PS_S5 = 3'd5,
      PS_G3 = 3'd7
   } pstate_e;

   typedef enum logic {CLR_ON_ONE, CLR_ON_ZERO} clr_kind_e;

   localparam int BIT_MAIN  = 0;
   localparam int BIT_VRM   = 1;
   localparam int BIT_WIDTH = 2;
   localparam int NBITS     = 3;

   function automatic clr_kind_e clr_kind(input int idx);
      return (idx == BIT_VRM) ? CLR_ON_ZERO : CLR_ON_ONE;
   endfunction

   function automatic logic is_running(input logic [2:0] s);
      return (s == PS_S0) || (s == PS_S1);
   endfunction

   function automatic logic is_deep_sleep(input logic [2:0] s);
      return (s == PS_S4) || (s == PS_S5);
   endfunction
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   initial begin
      assert (STAGES >= 2) else $error("pfs_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[s] <= '0;
         else if (s == 0) chain[s] <= d;
         else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pfs_width_timer.sv
module pfs_width_timer
   import pfs_pkg::*;
#(
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          sleep_n,
   input  logic          rsm_rst_n,
   input  logic [2:0]    pwr_state,
   input  logic [CW-1:0] limit,
   output logic          viol
);
   logic          sleep_q;
   logic          rsm_q;
   logic          running;
   logic [CW-1:0] cnt;
   logic [CW-1:0] cnt_nx;
   logic          arm_sleep;
   logic          arm_rsm;
   logic          release_ev;

   assign arm_sleep  = sleep_q & ~sleep_n & is_deep_sleep(pwr_state);
   assign arm_rsm    = ~rsm_q & rsm_rst_n & (pwr_state == PS_G3);
   assign release_ev = ~sleep_q & sleep_n;
   assign cnt_nx     = cnt + CW'(1);
   assign viol       = running & release_ev & rsm_rst_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sleep_q <= 1'b1;
         rsm_q   <= 1'b1;
      end else begin
         sleep_q <= sleep_n;
         rsm_q   <= rsm_rst_n;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (!rsm_rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (arm_sleep || arm_rsm) begin
         running <= 1'b1;
         cnt     <= '0;
      end else if (running) begin
         if (release_ev) begin
            running <= 1'b0;
         end else if (tick) begin
            cnt <= cnt_nx;
            if (cnt_nx >= limit) running <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pfs_sticky_bit.sv
module pfs_sticky_bit
   import pfs_pkg::*;
#(
   parameter clr_kind_e KIND = CLR_ON_ONE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic hw_clr,
   input  logic wr_en,
   input  logic wr_val,
   output logic q
);
   logic sw_clr;

   if (KIND == CLR_ON_ONE) begin : g_w1c
      assign sw_clr = wr_en & wr_val;
   end else begin : g_w0c
      assign sw_clr = wr_en & ~wr_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= 1'b0;
      else if (hw_clr) q <= 1'b0;
      else if (set)    q <= 1'b1;
      else if (sw_clr) q <= 1'b0;
   end
endmodule

// File: rtl/pwr_fault_status.sv
module pwr_fault_status
   import pfs_pkg::*;
#(
   parameter int TICKS_PER_SEC = 32768,
   parameter int SYNC_STAGES   = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rsm_rst_n,
   input  logic       sleep_n,
   input  logic       vrm_pg,
   input  logic       main_pg,
   input  logic [2:0] pwr_state,
   input  logic [1:0] min_sel,
   input  logic       wr_en,
   input  logic [2:0] wr_data,
   output logic [2:0] rd_data
);
   localparam int CW = $clog2(4 * TICKS_PER_SEC + 1);

   initial begin
      assert (TICKS_PER_SEC >= 1) else $error("pwr_fault_status: TICKS_PER_SEC must be positive");
      assert (SYNC_STAGES >= 2) else $error("pwr_fault_status: SYNC_STAGES must be at least 2");
   end

   logic [1:0]       pg_sync;
   logic             main_q;
   logic             vrm_smp;
   logic             main_fall;
   logic             vrm_fall;
   logic             width_viol;
   logic [CW-1:0]    limit;
   logic [NBITS-1:0] set_vec;
   logic [NBITS-1:0] hwclr_vec;

   pfs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({vrm_pg, main_pg}),
      .q     (pg_sync)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_q  <= 1'b0;
         vrm_smp <= 1'b0;
      end else begin
         main_q <= pg_sync[0];
         if (tick) vrm_smp <= pg_sync[1];
      end
   end

   assign main_fall = main_q & ~pg_sync[0] & is_running(pwr_state);
   assign vrm_fall  = tick & vrm_smp & ~pg_sync[1] & is_running(pwr_state);

   assign limit = CW'(TICKS_PER_SEC) * CW'({1'b0, min_sel} + 3'd1);

   pfs_width_timer #(.CW(CW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .sleep_n   (sleep_n),
      .rsm_rst_n (rsm_rst_n),
      .pwr_state (pwr_state),
      .limit     (limit),
      .viol      (width_viol)
   );

   always_comb begin
      set_vec              = '0;
      hwclr_vec            = '0;
      set_vec[BIT_MAIN]    = main_fall;
      set_vec[BIT_VRM]     = vrm_fall;
      set_vec[BIT_WIDTH]   = width_viol;
      hwclr_vec[BIT_MAIN]  = (pwr_state == PS_G3);
      hwclr_vec[BIT_WIDTH] = ~rsm_rst_n;
   end

   for (genvar i = 0; i < NBITS; i++) begin : g_bit
      pfs_sticky_bit #(.KIND(clr_kind(i))) u_bit (
         .clk    (clk),
         .rst_n  (rst_n),
         .set    (set_vec[i]),
         .hw_clr (hwclr_vec[i]),
         .wr_en  (wr_en),
         .wr_val (wr_data[i]),
         .q      (rd_data[i])
      );
   end
endmodule

// File: rtl/pfs_checker.sv
module pfs_checker
   import pfs_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       tick,
   input logic       rsm_rst_n,
   input logic [2:0] pwr_state,
   input logic       wr_en,
   input logic [2:0] wr_data,
   input logic [2:0] rd_data
);
   p_main_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[0]) |-> $past(is_running(pwr_state)));

   p_main_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[0] && !is_running(pwr_state)) |=> !rd_data[0]);

   p_main_g3_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == PS_G3) |=> !rd_data[0]);

   p_vrm_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[1]) |-> $past(tick));

   p_vrm_w0c_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[1] && !tick) |=> !rd_data[1]);

   p_vrm_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[1] && rd_data[1]) |=> rd_data[1]);

   p_width_rsm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rsm_rst_n |=> !rd_data[2]);
endmodule

bind pwr_fault_status pfs_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .rsm_rst_n (rsm_rst_n),
   .pwr_state (pwr_state),
   .wr_en     (wr_en),
   .wr_data   (wr_data),
   .rd_data   (rd_data)
);

// File: tb/pwr_fault_status_bench.sv
module pwr_fault_status_bench;
   localparam int TPS = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rsm_rst_n = 1'b1;
   logic       sleep_n = 1'b1;
   logic       vrm_pg = 1'b1;
   logic       main_pg = 1'b1;
   logic [2:0] pwr_state = 3'd0;
   logic [1:0] min_sel = 2'd0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_data = 3'b000;
   logic [2:0] rd_data;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [2:0] exp;
      string      tag;
   } item_t;
   item_t sb_q[$];

   always #10 clk = ~clk;

   pwr_fault_status #(.TICKS_PER_SEC(TPS)) u_pwr_fault_status (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rsm_rst_n(rsm_rst_n),
      .sleep_n(sleep_n), .vrm_pg(vrm_pg), .main_pg(main_pg),
      .pwr_state(pwr_state), .min_sel(min_sel), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data)
   );

   // monitor: pops expected items and compares away from the active edge
   initial begin
      forever begin
         wait (sb_q.size() > 0);
         @(negedge clk);
         begin
            item_t it;
            it = sb_q.pop_front();
            n_run++;
            if (rd_data !== it.exp) begin
               n_fail++;
               $display("FAIL %s: rd_data=%b expected=%b", it.tag, rd_data, it.exp);
            end
         end
      end
   end

   task automatic expect_rd(input logic [2:0] exp, input string tag);
      item_t it;
      it.exp = exp;
      it.tag = tag;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_tick(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
         idle(2);
      end
   endtask

   task automatic write(input logic [2:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      idle(1);
   endtask

   task automatic sleep_pulse(input logic [2:0] st, input int ticks);
      pwr_state = st;
      @(negedge clk) sleep_n = 1'b0;
      idle(1);
      do_tick(ticks);
      @(negedge clk) sleep_n = 1'b1;
      idle(2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(3);
      expect_rd(3'b000, "R1 reset state");
      do_tick(1);

      // R2: state gating of main power-good capture
      pwr_state = 3'd3;
      main_pg = 1'b0; idle(6);
      expect_rd(3'b000, "R2 fall in S3 ignored");
      main_pg = 1'b1; idle(6);
      pwr_state = 3'd0;
      main_pg = 1'b0; idle(6);
      expect_rd(3'b001, "R2 fall in S0 captured");
      main_pg = 1'b1; idle(6);

      // R3: write polarity and G3 clear
      write(3'b010);
      expect_rd(3'b001, "R3 write 0 keeps main flag");
      write(3'b011);
      expect_rd(3'b000, "R3 write 1 clears main flag");
      pwr_state = 3'd1;
      main_pg = 1'b0; idle(6);
      expect_rd(3'b001, "R2 fall in S1 captured");
      main_pg = 1'b1; idle(6);
      pwr_state = 3'd7; idle(2);
      expect_rd(3'b000, "R3 G3 clears main flag");
      pwr_state = 3'd0; idle(2);

      // R4: regulator power-good sampled on ticks
      vrm_pg = 1'b0; idle(4);
      vrm_pg = 1'b1; idle(4);
      do_tick(1);
      expect_rd(3'b000, "R4 glitch between ticks missed");
      vrm_pg = 1'b0; idle(4);
      do_tick(1);
      expect_rd(3'b010, "R4 fall across tick captured");
      vrm_pg = 1'b1; idle(4); do_tick(1);

      // R5: write-zero clear
      write(3'b010);
      expect_rd(3'b010, "R5 write 1 keeps regulator flag");
      write(3'b000);
      expect_rd(3'b000, "R5 write 0 clears regulator flag");
      pwr_state = 3'd3;
      vrm_pg = 1'b0; idle(4); do_tick(1);
      expect_rd(3'b000, "R4 fall in S3 ignored");
      vrm_pg = 1'b1; idle(4); do_tick(1);
      pwr_state = 3'd0;

      // R6 / R8: width timer, limit = (min_sel+1)*TPS ticks
      min_sel = 2'd0;
      sleep_pulse(3'd4, 1);
      expect_rd(3'b100, "R6 short assertion in S4 flagged");
      write(3'b110);
      expect_rd(3'b000, "R9 write 1 clears width flag");
      sleep_pulse(3'd5, 2);
      expect_rd(3'b000, "R6 assertion at minimum not flagged");
      min_sel = 2'd3;
      sleep_pulse(3'd5, 7);
      expect_rd(3'b100, "R8 select 3 short by one tick flagged");
      write(3'b110);
      sleep_pulse(3'd4, 8);
      expect_rd(3'b000, "R8 select 3 full width not flagged");
      min_sel = 2'd1;
      sleep_pulse(3'd4, 3);
      expect_rd(3'b100, "R8 select 1 three ticks flagged");

      // R9 / R7: resume reset clears, its release in G3 arms the timer
      pwr_state = 3'd7;
      @(negedge clk) sleep_n = 1'b0;
      rsm_rst_n = 1'b0; idle(2);
      expect_rd(3'b000, "R9 resume reset clears width flag");
      @(negedge clk) rsm_rst_n = 1'b1;
      idle(1);
      do_tick(1);
      @(negedge clk) sleep_n = 1'b1;
      idle(2);
      expect_rd(3'b100, "R7 resume release in G3 arms timer");
      write(3'b110);
      expect_rd(3'b000, "R9 flag cleared before S3 test");

      // R11: assertion in S3 does not arm
      sleep_pulse(3'd3, 1);
      expect_rd(3'b000, "R11 assertion in S3 not timed");

      // R10: set and clear in the same cycle
      pwr_state = 3'd0; idle(2);
      @(negedge clk) main_pg = 1'b0;
      @(negedge clk);
      @(negedge clk) begin wr_en = 1'b1; wr_data = 3'b011; end
      @(negedge clk) wr_en = 1'b0;
      idle(2);
      expect_rd(3'b001, "R10 set wins over same-cycle clear");
      main_pg = 1'b1; idle(4);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule